// File: doc/BRIEF.md
# Page Translation Cache with Table Refill

This block turns a processor's virtual addresses into physical addresses. The bits below the page boundary go through unchanged. The virtual page number above them is compared against a small fully associative set of cached translations. A match answers on the next cycle and does not touch memory.

When no cached translation matches, the block fetches the page's entry from a translation table held in memory through its own read port. If the entry is marked present, the block stores it and answers. If the entry is marked absent, the block answers with a fault flag and stores nothing.

Each answer carries a flag that tells an ordinary hit apart from an answer that needed a table read. A flush input discards every cached translation at once. The physical address may be wider than the virtual one.

Top module: `vpage_xlate`

## Requirements
- R1: The low OFS_W bits (default 12) of the physical address equal the same bits of the request. The answer is {physical page number, offset}.
- R2: A request that matches a valid cached page answers with rsp_valid in the cycle after it is accepted, with rsp_miss=0 and rsp_fault=0. No memory read is issued for it.
- R3: A request that matches nothing issues exactly one memory read at table_base + vpn*4. The sum is taken modulo 2^PA_W. The answer carries rsp_miss=1 and comes in the cycle after mem_rsp_valid.
- R4: The table word returned on mem_rsp_data holds the present flag in bit 0 and the physical page number in bits [PPN_W:1]. A present entry is installed, so the next request to that page hits.
- R5: An entry whose bit 0 is 0 gives rsp_fault=1 with rsp_miss=1. It installs nothing, so a repeat request to that page reads memory again.
- R6: Only one table read is serviced at a time. req_ready stays 0 from the cycle after a missing request is accepted until the cycle after its answer is produced.
- R7: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid stays 1 and mem_addr stays unchanged. table_base must be held steady during a table read.
- R8: A flush pulse invalidates all cached translations from the next cycle on, so earlier pages miss again.
- R9: An installed entry goes into the lowest-numbered empty slot. When all WAYS slots (default 8) are full, a round-robin pointer picks the victim. The pointer starts at slot 0 after reset and advances only when it is used.
- R10: The physical page number is PA_W-OFS_W bits wide (default 24, with PA_W=36 and VA_W=32). Its upper bits come from the table unchanged.
- R11: After reset, req_ready=1, rsp_valid=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| table_base | input | PA_W | Physical base address of the translation table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle answer strobe |
| rsp_paddr | output | PA_W | Translated physical address (zero on fault) |
| rsp_miss | output | 1 | Answer needed a table read |
| rsp_fault | output | 1 | Page not present |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | PA_W | Table word address |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | PA_W-OFS_W+1 | Table word: page number above, present flag in bit 0 |

## Verification
The bench aims at an absent page asked for twice in a row. A design that cached faulting entries would hit on the second try and never fault again. It also fills every slot and then evicts in order. A victim pointer that is wrong, or that advances on refills into empty slots, would evict a page the bench expects to hit. It checks pages at the very top of the virtual space and a wide physical page number, where a truncated width would corrupt the upper address bits. Finally, a memory that holds off its ready shows whether a design drops or changes the read address before the read is accepted.

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 36,
  parameter int OFS_W = 12,
  parameter int WAYS  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [PA_W-1:0]         table_base,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  output logic                    rsp_valid,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic                    rsp_miss,
  output logic                    rsp_fault,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [PA_W-1:0]         mem_addr,
  input  logic                    mem_rsp_valid,
  input  logic [PA_W-OFS_W:0]     mem_rsp_data
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ASK, S_WAIT} state_t;
  state_t state_q;

  logic [WAYS-1:0]  valid_q;
  logic [VPN_W-1:0] tag_q [WAYS];
  logic [PPN_W-1:0] ppn_q [WAYS];
  logic [IDX_W-1:0] rr_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFS_W-1:0] ofs_q;

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFS_W];
  wire [OFS_W-1:0] req_ofs = req_vaddr[OFS_W-1:0];
  wire             accept  = req_valid && req_ready;
  wire             fill    = (state_q == S_WAIT) && mem_rsp_valid;
  wire             present = mem_rsp_data[0];
  wire [PPN_W-1:0] new_ppn = mem_rsp_data[PPN_W:1];

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < WAYS; i++)
      if (valid_q[i] && tag_q[i] == req_vpn) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end

  logic             has_empty;
  logic [IDX_W-1:0] victim;
  always_comb begin
    has_empty = 1'b0;
    victim = rr_q;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        has_empty = 1'b1;
        victim = IDX_W'(i);
      end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_ASK);
  assign mem_addr      = table_base + PA_W'({vpn_q, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      valid_q   <= '0;
      rr_q      <= '0;
      vpn_q     <= '0;
      ofs_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          vpn_q <= req_vpn;
          ofs_q <= req_ofs;
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= {ppn_q[hit_idx], req_ofs};
          end else begin
            state_q <= S_ASK;
          end
        end
        S_ASK: if (mem_req_ready) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          state_q   <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_miss  <= 1'b1;
          rsp_fault <= !present;
          rsp_paddr <= present ? {new_ppn, ofs_q} : '0;
          if (present) begin
            valid_q[victim] <= 1'b1;
            if (!has_empty)
              rr_q <= (rr_q == IDX_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
      if (flush) valid_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill && present) begin
      tag_q[victim] <= vpn_q;
      ppn_q[victim] <= new_ppn;
    end
  end

  p_accept_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_valid && !rsp_miss) || mem_req_valid);

  p_single_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || state_q == S_WAIT) |-> !req_ready);

  p_walk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_addr));

  p_fill_answers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> rsp_valid && rsp_miss && req_ready);

  p_fault_no_install_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !$past(flush)) |-> valid_q == $past(valid_q));

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0);
endmodule

// File: tb/vpage_xlate_tb.sv
module vpage_xlate_tb;
  localparam int VA_W = 32, PA_W = 36, OFS_W = 12, WAYS = 8;
  localparam int PPN_W = PA_W - OFS_W;
  localparam logic [PA_W-1:0] BASE = 36'h8_4000_0000;
  localparam int NV = 9;
  localparam logic [31:0] V_VA [NV] = '{32'h0000_1234, 32'h0000_1FFC, 32'h0000_2000,
    32'h000E_E123, 32'h000E_E456, 32'h0000_1000, 32'h0000_2ABC, 32'hFFFF_F001, 32'hFFFF_FFFF};
  localparam logic [1:0] V_K [NV] = '{2'd1, 2'd0, 2'd1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd1, 2'd0};

  logic clk = 0, rst_n = 0, flush = 0, req_valid = 0;
  logic [PA_W-1:0] table_base = BASE;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_miss, rsp_fault, mem_req_valid;
  logic [PA_W-1:0] rsp_paddr, mem_addr;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [PPN_W:0] mem_rsp_data = '0;
  int checks = 0, fails = 0, reads = 0, hold = 0;
  logic [PA_W-1:0] last_addr = '0;

  always #10 clk = ~clk;

  vpage_xlate #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .WAYS(WAYS)) u_dut (
    .clk, .rst_n, .flush, .table_base, .req_valid, .req_ready, .req_vaddr,
    .rsp_valid, .rsp_paddr, .rsp_miss, .rsp_fault, .mem_req_valid, .mem_req_ready,
    .mem_addr, .mem_rsp_valid, .mem_rsp_data);

  function automatic logic [PPN_W-1:0] ppn_of(logic [19:0] vpn);
    return {vpn ^ 20'h5A5A5, 4'hC};
  endfunction
  function automatic logic present_of(logic [19:0] vpn);
    return vpn[7:0] != 8'hEE;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [PA_W-1:0] a;
        logic [19:0] v;
        a = mem_addr;
        repeat (hold) begin
          @(negedge clk);
          chk(mem_req_valid && mem_addr == a, "R7", "read held", {28'd0, mem_addr}, {28'd0, a});
        end
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        reads++;
        last_addr = a;
        v = 20'((a - BASE) >> 2);
        repeat (hold) @(negedge clk);
        mem_rsp_valid = 1;
        mem_rsp_data = {ppn_of(v), present_of(v)};
        @(negedge clk);
        mem_rsp_valid = 0;
      end
    end
  end

  task automatic xlate(logic [31:0] va, logic [1:0] kind);
    int r0, w;
    logic [19:0] vpn;
    vpn = va[31:12];
    r0 = reads;
    req_vaddr = va;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (kind != 0)
      chk(!req_ready, "R6", "ready low in walk", {63'd0, req_ready}, 64'd0);
    w = 0;
    while (!rsp_valid && w < 60) begin
      @(negedge clk);
      w++;
    end
    chk(rsp_valid, "R2", "answer seen", {63'd0, rsp_valid}, 64'd1);
    if (kind == 0) begin
      chk(w == 0, "R2", "hit latency", 64'(w), 64'd0);
      chk(reads == r0, "R2", "hit reads", 64'(reads - r0), 64'd0);
      chk(!rsp_miss && !rsp_fault, "R2", "hit flags", {62'd0, rsp_miss, rsp_fault}, 64'd0);
    end else begin
      chk(reads == r0 + 1, "R3", "one table read", 64'(reads - r0), 64'd1);
      chk(last_addr == BASE + {vpn, 2'b00}, "R3", "table addr", {28'd0, last_addr},
          {28'd0, BASE + {14'd0, vpn, 2'b00}});
      chk(rsp_miss, "R3", "miss flag", {63'd0, rsp_miss}, 64'd1);
    end
    if (kind == 2)
      chk(rsp_fault, "R5", "fault flag", {63'd0, rsp_fault}, 64'd1);
    else begin
      chk(!rsp_fault, "R4", "no fault", {63'd0, rsp_fault}, 64'd0);
      chk(rsp_paddr == {ppn_of(vpn), va[11:0]}, "R1 R10", "paddr", {28'd0, rsp_paddr},
          {28'd0, ppn_of(vpn), va[11:0]});
    end
    @(negedge clk);
    chk(!rsp_valid, "R2", "single strobe", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R11", "reset state",
        {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);
    for (int i = 0; i < NV; i++) begin
      hold = i % 3;
      xlate(V_VA[i], V_K[i]);
    end
    hold = 1;
    flush = 1;
    @(negedge clk);
    flush = 0;
    xlate(32'h0000_1040, 2'd1); // R8 flushed page misses
    for (int p = 'h10; p <= 'h16; p++) xlate({12'd0, 8'(p), 12'h0AB}, 2'd1);
    xlate(32'h0002_0000, 2'd1); // R9 evicts slot 0
    xlate(32'h0001_0000, 2'd0);
    xlate(32'h0000_1000, 2'd1); // R9 evicts slot 1
    xlate(32'h0001_0000, 2'd1); // R9 evicts slot 2
    xlate(32'h0001_2000, 2'd0);
    xlate(32'h0002_0FFF, 2'd0);
    xlate(32'h0001_1000, 2'd1); // R9 evicted earlier
    xlate(32'h000E_E000, 2'd2); // R5 still faults
    finish_run();
  end
endmodule